// File: doc/BRIEF.md
# Stack Machine Operate Unit

This block executes the register-only "operate" instructions of a processor that keeps its working values on a three-deep register stack (A on top, then B, then C). The instruction front end gathers the full operation code from the prefixed operand. It then hands over that code, the current A, B and C values, the workspace pointer and the address of the following instruction, and raises `op_valid` for one cycle. One clock edge later the unit presents the new stack and workspace values with `res_valid`. The front end writes these values back into its own register copies.

The unit owns three pieces of state. Two front-pointer registers are written by the two front-pointer store operations. A sticky error flag is raised by signed overflow in add or subtract. A code the unit does not implement raises `illegal_out` for that one result cycle. In that case the stack and workspace values come back unchanged, and the front pointers and the error flag keep their values.

Top module: `sm_opr_unit`

## Requirements
- R1: A result appears exactly one cycle after an accepted operation. `res_valid` is high in the cycle after `op_valid` was sampled high and is low otherwise. Between results, every output holds its value.
- R2: Reverse (code 0x00) exchanges A and B; C and the workspace pointer are unchanged.
- R3: Add (code 0x05) makes A equal to B + A (modulo 2^32) and moves C into B; C and the workspace pointer are unchanged.
- R4: Subtract (code 0x0C) makes A equal to B minus the old A (modulo 2^32) and moves C into B; C and the workspace pointer are unchanged.
- R5: Add or subtract whose true signed 32-bit result does not fit sets `err_out`. Once set, `err_out` stays set through any later operation, including non-overflowing arithmetic; only reset clears it.
- R6: Load pointer to instruction (code 0x1B) adds `next_iptr` to A; B, C and the workspace pointer are unchanged.
- R7: Minimum integer (code 0x42) pushes 0x80000000: C takes the old B, B takes the old A, A takes 0x80000000.
- R8: Byte count (code 0x34) shifts A left by 2 with B and C unchanged. Word count (code 0x3F) pushes: C takes the old B, B takes the old A AND 3, A takes the old A shifted right logically by 2.
- R9: General adjust workspace (code 0x3C) loads the workspace pointer from A with bits 1:0 cleared and puts the old workspace pointer into A; B and C are unchanged.
- R10: Code 0x18 copies A into front pointer 0, code 0x1C copies A into front pointer 1. Both then pop: A takes B, B takes C, and C is unchanged. The other front pointer, and both pointers outside these operations, keep their values.
- R11: Any other code raises `illegal_out` in its result cycle only. A, B, C and the workspace pointer are returned as given, and `err_out` and both front pointers are unchanged.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | CODE_W | Complete operation code |
| a_in | input | DATA_W | Current top of stack |
| b_in | input | DATA_W | Current second stack entry |
| c_in | input | DATA_W | Current third stack entry |
| wptr_in | input | DATA_W | Current workspace pointer |
| next_iptr | input | DATA_W | Address of the following instruction |
| res_valid | output | 1 | Result cycle |
| a_out | output | DATA_W | New top of stack |
| b_out | output | DATA_W | New second entry |
| c_out | output | DATA_W | New third entry |
| wptr_out | output | DATA_W | New workspace pointer |
| fptr0_out | output | DATA_W | Front-pointer register 0 |
| fptr1_out | output | DATA_W | Front-pointer register 1 |
| err_out | output | 1 | Sticky arithmetic error flag |
| illegal_out | output | 1 | Unimplemented code in this result cycle |

## Verification
The hardest state to reach is a set error flag meeting a later clean add. It takes an overflowing operation first, so the bench forces signed overflow from both directions: a positive sum wrapping negative, and a subtract of opposite-signed operands. It then issues non-overflowing add and subtract, an illegal code and the other operations, and checks that the flag never drops. Illegal codes are placed between front-pointer stores, so that an unchanged pointer is visible at the ports.

// File: rtl/sm_opr_pkg.sv
package sm_opr_pkg;

   // Operation codes of the operate class (completed operand value)
   localparam int unsigned OPC_REV  = 'h00;
   localparam int unsigned OPC_ADD  = 'h05;
   localparam int unsigned OPC_SUB  = 'h0C;
   localparam int unsigned OPC_FP0  = 'h18;
   localparam int unsigned OPC_LDPI = 'h1B;
   localparam int unsigned OPC_FP1  = 'h1C;
   localparam int unsigned OPC_BCNT = 'h34;
   localparam int unsigned OPC_GAJW = 'h3C;
   localparam int unsigned OPC_WCNT = 'h3F;
   localparam int unsigned OPC_MINT = 'h42;

   // Widest code value above needs this many bits
   localparam int unsigned OPC_MIN_W = 7;

   // Number of front-pointer registers
   localparam int unsigned FP_COUNT = 2;

   typedef enum logic [3:0] {
      K_REV, K_ADD, K_SUB, K_LDPI, K_MINT,
      K_BCNT, K_WCNT, K_GAJW, K_FP0, K_FP1, K_ILL
   } opr_kind_e;

endpackage

// File: rtl/sm_opr_decode.sv
module sm_opr_decode
   import sm_opr_pkg::*;
#(
   parameter int unsigned CODE_W = 8
) (
   input  logic [CODE_W-1:0] code,
   output opr_kind_e         kind,
   output logic              illegal
);

   localparam logic [CODE_W-1:0] C_REV  = CODE_W'(OPC_REV);
   localparam logic [CODE_W-1:0] C_ADD  = CODE_W'(OPC_ADD);
   localparam logic [CODE_W-1:0] C_SUB  = CODE_W'(OPC_SUB);
   localparam logic [CODE_W-1:0] C_LDPI = CODE_W'(OPC_LDPI);
   localparam logic [CODE_W-1:0] C_MINT = CODE_W'(OPC_MINT);
   localparam logic [CODE_W-1:0] C_BCNT = CODE_W'(OPC_BCNT);
   localparam logic [CODE_W-1:0] C_WCNT = CODE_W'(OPC_WCNT);
   localparam logic [CODE_W-1:0] C_GAJW = CODE_W'(OPC_GAJW);
   localparam logic [CODE_W-1:0] C_FP0  = CODE_W'(OPC_FP0);
   localparam logic [CODE_W-1:0] C_FP1  = CODE_W'(OPC_FP1);

   always_comb begin
      case (code)
         C_REV:   kind = K_REV;
         C_ADD:   kind = K_ADD;
         C_SUB:   kind = K_SUB;
         C_LDPI:  kind = K_LDPI;
         C_MINT:  kind = K_MINT;
         C_BCNT:  kind = K_BCNT;
         C_WCNT:  kind = K_WCNT;
         C_GAJW:  kind = K_GAJW;
         C_FP0:   kind = K_FP0;
         C_FP1:   kind = K_FP1;
         default: kind = K_ILL;
      endcase
   end

   assign illegal = (kind == K_ILL);

endmodule

// File: rtl/sm_opr_arith.sv
module sm_opr_arith #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] top,      // A
   input  logic [DATA_W-1:0] second,   // B
   output logic [DATA_W-1:0] sum,      // B + A
   output logic [DATA_W-1:0] diff,     // B - A
   output logic              ovf_add,
   output logic              ovf_sub
);

   localparam int unsigned MSB = DATA_W - 1;

   assign sum  = second + top;
   assign diff = second - top;

   // Signed overflow: operands agree in sign (add) or differ (sub),
   // and the result sign departs from that of B.
   assign ovf_add = (second[MSB] == top[MSB]) && (sum[MSB]  != second[MSB]);
   assign ovf_sub = (second[MSB] != top[MSB]) && (diff[MSB] != second[MSB]);

endmodule

// File: rtl/sm_opr_shuffle.sv
module sm_opr_shuffle
   import sm_opr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  opr_kind_e           kind,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   input  logic [DATA_W-1:0]   c,
   input  logic [DATA_W-1:0]   w,
   input  logic [DATA_W-1:0]   nip,
   input  logic [DATA_W-1:0]   sum,
   input  logic [DATA_W-1:0]   diff,
   output logic [DATA_W-1:0]   na,
   output logic [DATA_W-1:0]   nb,
   output logic [DATA_W-1:0]   nc,
   output logic [DATA_W-1:0]   nw,
   output logic [FP_COUNT-1:0] fp_we,
   output logic [DATA_W-1:0]   fp_wd
);

   localparam int unsigned       ALIGN      = $clog2(DATA_W / 8);
   localparam logic [DATA_W-1:0] LOW_MASK   = DATA_W'((1 << ALIGN) - 1);
   localparam logic [DATA_W-1:0] ALIGN_MASK = ~LOW_MASK;
   localparam logic [DATA_W-1:0] MIN_INT    = {1'b1, {(DATA_W-1){1'b0}}};

   always_comb begin
      na    = a;
      nb    = b;
      nc    = c;
      nw    = w;
      fp_we = '0;
      fp_wd = a;
      case (kind)
         K_REV:  begin na = b;          nb = a;             end
         K_ADD:  begin na = sum;        nb = c;             end
         K_SUB:  begin na = diff;       nb = c;             end
         K_LDPI: begin na = a + nip;                        end
         K_MINT: begin na = MIN_INT;    nb = a;    nc = b;  end
         K_BCNT: begin na = a << ALIGN;                     end
         K_WCNT: begin na = a >> ALIGN; nb = a & LOW_MASK; nc = b; end
         K_GAJW: begin nw = a & ALIGN_MASK; na = w;         end
         K_FP0:  begin fp_we[0] = 1'b1; na = b; nb = c;     end
         K_FP1:  begin fp_we[1] = 1'b1; na = b; nb = c;     end
         default: ;
      endcase
   end

endmodule

// File: rtl/sm_opr_unit.sv
module sm_opr_unit
   import sm_opr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [CODE_W-1:0] op_code,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [DATA_W-1:0] c_in,
   input  logic [DATA_W-1:0] wptr_in,
   input  logic [DATA_W-1:0] next_iptr,
   output logic              res_valid,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] b_out,
   output logic [DATA_W-1:0] c_out,
   output logic [DATA_W-1:0] wptr_out,
   output logic [DATA_W-1:0] fptr0_out,
   output logic [DATA_W-1:0] fptr1_out,
   output logic              err_out,
   output logic              illegal_out
);

   localparam int unsigned ALIGN = $clog2(DATA_W / 8);

   // Elaboration-time parameter checks
   if ((DATA_W < 16) || ((DATA_W % 8) != 0)) begin : g_bad_data_w
      $error("sm_opr_unit: DATA_W must be a multiple of 8 and at least 16");
   end
   if (CODE_W < OPC_MIN_W) begin : g_bad_code_w
      $error("sm_opr_unit: CODE_W too narrow for the operation codes");
   end

   opr_kind_e                kind;
   logic                     illegal;
   logic [DATA_W-1:0]        sum, diff, na, nb, nc, nw, fp_wd;
   logic                     ovf_add, ovf_sub, ovf_hit;
   logic [FP_COUNT-1:0]      fp_we;
   logic [DATA_W-1:0]        fp_q [FP_COUNT];

   sm_opr_decode #(.CODE_W(CODE_W)) u_decode (
      .code    (op_code),
      .kind    (kind),
      .illegal (illegal)
   );

   sm_opr_arith #(.DATA_W(DATA_W)) u_arith (
      .top     (a_in),
      .second  (b_in),
      .sum     (sum),
      .diff    (diff),
      .ovf_add (ovf_add),
      .ovf_sub (ovf_sub)
   );

   sm_opr_shuffle #(.DATA_W(DATA_W)) u_shuffle (
      .kind  (kind),
      .a     (a_in),
      .b     (b_in),
      .c     (c_in),
      .w     (wptr_in),
      .nip   (next_iptr),
      .sum   (sum),
      .diff  (diff),
      .na    (na),
      .nb    (nb),
      .nc    (nc),
      .nw    (nw),
      .fp_we (fp_we),
      .fp_wd (fp_wd)
   );

   assign ovf_hit = ((kind == K_ADD) && ovf_add) || ((kind == K_SUB) && ovf_sub);

   // Stack, workspace, handshake and sticky error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         illegal_out <= 1'b0;
         err_out     <= 1'b0;
         a_out       <= '0;
         b_out       <= '0;
         c_out       <= '0;
         wptr_out    <= '0;
      end else begin
         res_valid   <= op_valid;
         illegal_out <= op_valid && illegal;
         if (op_valid) begin
            a_out    <= na;
            b_out    <= nb;
            c_out    <= nc;
            wptr_out <= nw;
            if (ovf_hit) err_out <= 1'b1;
         end
      end
   end

   // Front-pointer registers
   for (genvar gi = 0; gi < FP_COUNT; gi++) begin : g_fp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    fp_q[gi] <= '0;
         else if (op_valid && fp_we[gi]) fp_q[gi] <= fp_wd;
      end
   end

   assign fptr0_out = fp_q[0];
   assign fptr1_out = fp_q[1];

   // Assertions
   assert_res_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);
   assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);
   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_out |=> err_out);
   assert_ill_in_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_out |-> res_valid);
   assert_ill_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_out |-> (a_out == $past(a_in) && b_out == $past(b_in) &&
                       c_out == $past(c_in) && wptr_out == $past(wptr_in)));
   assert_fp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> ($stable(fptr0_out) && $stable(fptr1_out)));
   assert_gajw_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(op_code) == CODE_W'(OPC_GAJW)) |-> (wptr_out[ALIGN-1:0] == '0));
   assert_mint_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(op_code) == CODE_W'(OPC_MINT)) |->
         (a_out == {1'b1, {(DATA_W-1){1'b0}}} && b_out == $past(a_in) && c_out == $past(b_in)));

endmodule

// File: tb/sm_opr_unit_bench.sv
`timescale 1ns/1ps
module sm_opr_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  op_code = '0;
   logic [31:0] a_in = '0, b_in = '0, c_in = '0, wptr_in = '0, next_iptr = '0;
   logic        res_valid, err_out, illegal_out;
   logic [31:0] a_out, b_out, c_out, wptr_out, fptr0_out, fptr1_out;

   always #2.5 clk = ~clk;

   sm_opr_unit u_sm_opr_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .a_in(a_in), .b_in(b_in), .c_in(c_in), .wptr_in(wptr_in), .next_iptr(next_iptr),
      .res_valid(res_valid), .a_out(a_out), .b_out(b_out), .c_out(c_out),
      .wptr_out(wptr_out), .fptr0_out(fptr0_out), .fptr1_out(fptr1_out),
      .err_out(err_out), .illegal_out(illegal_out)
   );

   typedef struct {
      logic [31:0] a, b, c, w, f0, f1;
      logic        err, ill;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;
   logic [31:0] m_f0 = '0, m_f1 = '0;
   logic        m_err = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Driver: compute expectation from the requirements, queue it, apply stimulus
   task automatic run_op(input logic [7:0] code, input logic [31:0] a, b, c, w, nip,
                         input string tag);
      exp_t e;
      logic [31:0] r;
      e.a = a; e.b = b; e.c = c; e.w = w; e.ill = 1'b0; e.tag = tag;
      case (code)
         8'h00: begin e.a = b; e.b = a; end
         8'h05: begin r = b + a; e.a = r; e.b = c;
                  if (a[31] == b[31] && r[31] != b[31]) m_err = 1'b1; end
         8'h0C: begin r = b - a; e.a = r; e.b = c;
                  if (a[31] != b[31] && r[31] != b[31]) m_err = 1'b1; end
         8'h1B: e.a = a + nip;
         8'h42: begin e.a = 32'h8000_0000; e.b = a; e.c = b; end
         8'h34: e.a = a << 2;
         8'h3F: begin e.a = a >> 2; e.b = a & 32'h3; e.c = b; end
         8'h3C: begin e.w = a & ~32'h3; e.a = w; end
         8'h18: begin m_f0 = a; e.a = b; e.b = c; end
         8'h1C: begin m_f1 = a; e.a = b; e.b = c; end
         default: e.ill = 1'b1;
      endcase
      e.f0 = m_f0; e.f1 = m_f1; e.err = m_err;
      sb_q.push_back(e);
      @(negedge clk);
      op_valid = 1'b1; op_code = code;
      a_in = a; b_in = b; c_in = c; wptr_in = w; next_iptr = nip;
      @(negedge clk);
      op_valid = 1'b0;
      a_in = ~a; b_in = ~b; c_in = ~c; wptr_in = ~w;
   endtask

   // Monitor: pop and compare on every result cycle
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R1", "unexpected result", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(a_out == e.a,          e.tag, "A",       a_out, e.a);
               check(b_out == e.b,          e.tag, "B",       b_out, e.b);
               check(c_out == e.c,          e.tag, "C",       c_out, e.c);
               check(wptr_out == e.w,       e.tag, "Wptr",    wptr_out, e.w);
               check(fptr0_out == e.f0,     e.tag, "fptr0",   fptr0_out, e.f0);
               check(fptr1_out == e.f1,     e.tag, "fptr1",   fptr1_out, e.f1);
               check(err_out == e.err,      e.tag, "err",     32'(err_out), 32'(e.err));
               check(illegal_out == e.ill,  e.tag, "illegal", 32'(illegal_out), 32'(e.ill));
            end
         end
      end
   end

   // Watchdog
   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset values
      check(res_valid == 0 && illegal_out == 0 && err_out == 0, "R12", "flags",
            {29'd0, res_valid, illegal_out, err_out}, 32'd0);
      check((a_out | b_out | c_out | wptr_out | fptr0_out | fptr1_out) == 0, "R12",
            "data", a_out | b_out | c_out | wptr_out | fptr0_out | fptr1_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(8'h00, 32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h100, 32'h0, "R2");
      run_op(8'h05, 32'h0000_0010, 32'h0000_0020, 32'hCCCC_0000, 32'h100, 32'h0, "R3");
      run_op(8'h05, 32'hFFFF_FFFF, 32'h0000_0005, 32'h0, 32'h100, 32'h0, "R3");
      run_op(8'h0C, 32'h0000_0003, 32'h0000_0010, 32'h77, 32'h100, 32'h0, "R4");
      run_op(8'h0C, 32'h0000_0010, 32'h0000_0003, 32'h77, 32'h100, 32'h0, "R4");
      run_op(8'h1B, 32'h0000_0020, 32'h5, 32'h6, 32'h100, 32'h0000_4000, "R6");
      run_op(8'h42, 32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'h100, 32'h0, "R7");
      run_op(8'h34, 32'h4000_0013, 32'h1, 32'h2, 32'h100, 32'h0, "R8");
      run_op(8'h3F, 32'h0000_0013, 32'h0000_0099, 32'h55, 32'h100, 32'h0, "R8");
      run_op(8'h3C, 32'h0000_1007, 32'h1, 32'h2, 32'h0000_2000, 32'h0, "R9");
      run_op(8'h18, 32'hF0F0_0000, 32'h0000_00B0, 32'h0000_00C0, 32'h100, 32'h0, "R10");
      run_op(8'h01, 32'h1234_5678, 32'h9, 32'hA, 32'h100, 32'h0, "R11");
      run_op(8'h1C, 32'h0F0F_0000, 32'h0000_00B1, 32'h0000_00C1, 32'h100, 32'h0, "R10");
      run_op(8'h7F, 32'hDEAD_BEEF, 32'hCAFE_0000, 32'h1, 32'h44, 32'h0, "R11");
      // R5: positive overflow on add, then clean arithmetic keeps the flag
      run_op(8'h05, 32'h0000_0001, 32'h7FFF_FFFF, 32'h0, 32'h100, 32'h0, "R5");
      run_op(8'h05, 32'h0000_0001, 32'h0000_0001, 32'h0, 32'h100, 32'h0, "R5");
      run_op(8'h0C, 32'h0000_0001, 32'h0000_0005, 32'h0, 32'h100, 32'h0, "R5");
      run_op(8'hFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R11");
      run_op(8'h00, 32'h1, 32'h2, 32'h3, 32'h100, 32'h0, "R5");

      // R1: idle cycles produce no result and hold outputs
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R1", "idle res_valid", 32'(res_valid), 32'd0);
      check(a_out == 32'h2 && b_out == 32'h1, "R1", "hold A", a_out, 32'h2);
      check(fptr0_out == m_f0 && fptr1_out == m_f1, "R10", "fptr hold", fptr1_out, m_f1);

      // R5: reset clears the flag, then sub overflow from the negative side sets it
      rst_n = 1'b0;
      @(negedge clk);
      check(err_out == 1'b0, "R12", "err after reset", 32'(err_out), 32'd0);
      rst_n = 1'b1;
      m_err = 1'b0; m_f0 = '0; m_f1 = '0;
      @(negedge clk);
      run_op(8'h0C, 32'h0000_0001, 32'h8000_0000, 32'h0, 32'h100, 32'h0, "R5");
      run_op(8'h0C, 32'h8000_0000, 32'h0000_0000, 32'h0, 32'h100, 32'h0, "R5");

      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R1", "pending results", 32'(sb_q.size()), 32'd0);
      report();
   end

endmodule